// File: doc/BRIEF.md
# Memory Window Decoder with Byte-Lane Steering

This block sits between a 32-bit processor bus and one memory region. It decides whether an incoming byte address falls inside a programmable, naturally aligned memory window. For a hit it reports the offset of the address inside that window and works out which of the four byte lanes of the 32-bit data word the access touches. Write data arrives right-justified and is moved onto those lanes. Read data is taken from those lanes and returned right-justified and zero-extended.

A single configuration word programs the window. It carries the window start address, a two-bit memory-device size code and a byte-numbering bit. The window size follows from the size code: there is no separate length or mask register. The byte-numbering bit can reverse the lane order at run time, which allows big- and little-endian masters to share the memory. The configuration is held in a register. All address decode and lane steering is combinational. Until the first configuration write the block never selects.

Top module: `memwin_lane_steer`

## Requirements
- R1: After reset and before the first configuration write, `blk_sel` is 0 and `lane_en`, `blk_offset`, `mem_wr_data` and `rd_data` are all zero, whatever the address.
- R2: A configuration write (`cfg_we` high at a rising edge) takes effect from the next cycle. In the same cycle the outputs still follow the earlier configuration. The configuration word fields are:
  - base address in bits 31:21,
  - size code in bits 1:0,
  - byte order in bit 16.
- R3: With size code 00 the window is 2 MB, with 01 it is 8 MB and with 10 it is 32 MB. `blk_sel` is 1 exactly when the address bits at and above log2(window size) equal the same base bits.
- R4: Base bits below log2(window size) are ignored. The window is always aligned to its own size.
- R5: Size code 11 is reserved: `blk_sel` stays 0 for every address.
- R6: When selected, `blk_offset` equals the address modulo the window size. Otherwise it is zero.
- R7: With byte order 0, a byte access (`acc_size` 00) enables only lane `addr[1:0]`. Lane k carries data bits 8k+7:8k.
- R8: With byte order 1, a byte access enables only lane 3 - `addr[1:0]`.
- R9: A halfword access (`acc_size` 01) ignores `addr[0]`.
  - With byte order 0 it enables lanes {2·addr[1]+1, 2·addr[1]}.
  - With byte order 1 the choice is mirrored: addr[1]=0 enables lanes 3 and 2, and addr[1]=1 enables lanes 1 and 0.
- R10: A word access (`acc_size` 10 or 11) enables all four lanes. The data passes unchanged in both byte orders. Bit order inside a byte never changes.
- R11: On a hit, `mem_wr_data` holds `wr_data[8n-1:0]` shifted onto the lowest enabled lane, where n is the number of enabled lanes. All other lanes are zero. On a miss it is zero.
- R12: On a hit, `rd_data` holds the enabled lanes of `mem_rd_data`, shifted down to bit 0 and zero-extended. On a miss it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | 32 | Configuration word (base 31:21, order 16, size 1:0) |
| bus_addr | input | 32 | Byte address of the current access |
| acc_size | input | 2 | 00 byte, 01 halfword, 1x word |
| wr_data | input | 32 | Right-justified write data from the master |
| mem_rd_data | input | 32 | Lane-ordered read data from memory |
| blk_sel | output | 1 | Address lies inside the configured window |
| blk_offset | output | 32 | Offset of the address inside the window |
| lane_en | output | 4 | Per-lane byte enables |
| mem_wr_data | output | 32 | Write data placed on the enabled lanes |
| rd_data | output | 32 | Right-justified, zero-extended read data |

## Verification
Assertions check several properties on every cycle:
- the block stays quiet before configuration and with the reserved size code;
- a hit always has matching upper address bits and an offset that fits the window;
- each access size enables the right number of lanes;
- nothing is driven on a miss.

Some behaviour only the bench's reference model can show:
- which lanes are chosen in each byte order;
- the exact byte positions of steered write and read data;
- the one-cycle latency of a configuration load;
- that low base bits are ignored for larger windows.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int unsigned SIZE_CODE_W = 2;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WIDE = 2'b11
    } acc_e;

endpackage

// File: rtl/memwin_cfg_reg.sv
module memwin_cfg_reg
    import memwin_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MIN_LOG2  = 21,
    parameter int unsigned ORDER_BIT = 16,
    parameter int unsigned SIZE_LSB  = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      wdata,
    output logic                   valid,
    output logic                   big,
    output logic [SIZE_CODE_W-1:0] dsz,
    output logic [ADDR_W-1:0]      base
);

    typedef struct packed {
        logic                   valid;
        logic                   big;
        logic [SIZE_CODE_W-1:0] dsz;
        logic [ADDR_W-1:0]      base;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.valid = 1'b1;
            cfg_d.big   = wdata[ORDER_BIT];
            cfg_d.dsz   = wdata[SIZE_LSB +: SIZE_CODE_W];
            cfg_d.base  = {wdata[ADDR_W-1:MIN_LOG2], {MIN_LOG2{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign valid = cfg_q.valid;
    assign big   = cfg_q.big;
    assign dsz   = cfg_q.dsz;
    assign base  = cfg_q.base;

    // a load becomes visible one cycle later and never un-configures
    assert_load_visible_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (valid && dsz == $past(wdata[SIZE_LSB +: SIZE_CODE_W])
                && big == $past(wdata[ORDER_BIT])));

    assert_valid_sticky_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

endmodule

// File: rtl/memwin_window_match.sv
module memwin_window_match
    import memwin_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MIN_LOG2  = 21,
    parameter int unsigned STEP_LOG2 = 2,
    parameter int unsigned NUM_SIZES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid,
    input  logic [SIZE_CODE_W-1:0] dsz,
    input  logic [ADDR_W-1:0]      base,
    input  logic [ADDR_W-1:0]      addr,
    output logic                   sel,
    output logic [ADDR_W-1:0]      offset
);

    logic [NUM_SIZES-1:0] hit;
    logic [ADDR_W-1:0]    offs [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int unsigned BL = MIN_LOG2 + k * STEP_LOG2;
        assign hit[k]  = (addr[ADDR_W-1:BL] == base[ADDR_W-1:BL]);
        assign offs[k] = addr & ((ADDR_W'(1) << BL) - ADDR_W'(1));
    end

    always_comb begin
        sel    = 1'b0;
        offset = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (valid && dsz == SIZE_CODE_W'(k) && hit[k]) begin
                sel    = 1'b1;
                offset = offs[k];
            end
        end
    end

    int blog;
    assign blog = int'(MIN_LOG2) + int'(dsz) * int'(STEP_LOG2);

    assert_sel_needs_cfg_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> valid);

    assert_reserved_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (int'(dsz) < int'(NUM_SIZES)));

    assert_upper_bits_match_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (((addr ^ base) >> blog) == '0));

    assert_offset_fits_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> ((offset >> blog) == '0));

    assert_offset_zero_miss_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (offset == '0));

endmodule

// File: rtl/memwin_lane_map.sv
module memwin_lane_map
    import memwin_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      big,
    input  logic [1:0]                acc,
    input  logic [$clog2(LANES)-1:0]  lane_addr,
    input  logic [LANES*BYTE_W-1:0]   wr_data,
    input  logic [LANES*BYTE_W-1:0]   mem_rd_data,
    output logic [LANES-1:0]          lane_en,
    output logic [LANES*BYTE_W-1:0]   mem_wr_data,
    output logic [LANES*BYTE_W-1:0]   rd_data
);

    localparam int unsigned IW = $clog2(LANES);

    logic [IW:0] cnt;
    logic [IW:0] first_w;

    always_comb begin
        case (acc_e'(acc))
            ACC_BYTE: begin
                cnt     = (IW+1)'(1);
                first_w = {1'b0, lane_addr};
            end
            ACC_HALF: begin
                cnt     = (IW+1)'(2);
                first_w = {1'b0, lane_addr[IW-1:1], 1'b0};
            end
            default: begin
                cnt     = (IW+1)'(LANES);
                first_w = '0;
            end
        endcase
        if (big) begin
            first_w = (IW+1)'(LANES) - cnt - first_w;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic          in_grp;
        logic          rd_on;
        logic [IW-1:0] rel;
        logic [IW-1:0] src;

        assign in_grp = en && ((IW+1)'(i) >= first_w) && ((IW+1)'(i) < first_w + cnt);
        assign rd_on  = en && ((IW+1)'(i) < cnt);
        assign rel    = IW'(i) - first_w[IW-1:0];
        assign src    = IW'(i) + first_w[IW-1:0];

        assign lane_en[i] = in_grp;
        assign mem_wr_data[i*BYTE_W +: BYTE_W] =
            in_grp ? wr_data[int'(rel)*BYTE_W +: BYTE_W] : '0;
        assign rd_data[i*BYTE_W +: BYTE_W] =
            rd_on ? mem_rd_data[int'(src)*BYTE_W +: BYTE_W] : '0;
    end

    assert_byte_one_lane_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc == ACC_BYTE) |-> ($countones(lane_en) == 1));

    assert_byte_mirror_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc == ACC_BYTE && big) |-> lane_en[LANES-1-int'(lane_addr)]);

    assert_half_two_lanes_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc == ACC_HALF) |-> ($countones(lane_en) == 2));

    assert_word_all_lanes_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc[1]) |-> (&lane_en));

    assert_miss_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (lane_en == '0 && mem_wr_data == '0));

    assert_miss_read_zero_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rd_data == '0));

endmodule

// File: rtl/memwin_lane_steer.sv
module memwin_lane_steer
    import memwin_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned LANES        = 4,
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned MIN_BLK_LOG2 = 21,
    parameter int unsigned STEP_LOG2    = 2,
    parameter int unsigned NUM_SIZES    = 3,
    parameter int unsigned ORDER_BIT    = 16,
    parameter int unsigned SIZE_LSB     = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_wdata,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              acc_size,
    input  logic [LANES*BYTE_W-1:0] wr_data,
    input  logic [LANES*BYTE_W-1:0] mem_rd_data,
    output logic                    blk_sel,
    output logic [ADDR_W-1:0]       blk_offset,
    output logic [LANES-1:0]        lane_en,
    output logic [LANES*BYTE_W-1:0] mem_wr_data,
    output logic [LANES*BYTE_W-1:0] rd_data
);

    localparam int unsigned IW = $clog2(LANES);

    logic                   cfg_valid;
    logic                   cfg_big;
    logic [SIZE_CODE_W-1:0] cfg_dsz;
    logic [ADDR_W-1:0]      cfg_base;

    memwin_cfg_reg #(
        .ADDR_W    (ADDR_W),
        .MIN_LOG2  (MIN_BLK_LOG2),
        .ORDER_BIT (ORDER_BIT),
        .SIZE_LSB  (SIZE_LSB)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .valid (cfg_valid),
        .big   (cfg_big),
        .dsz   (cfg_dsz),
        .base  (cfg_base)
    );

    memwin_window_match #(
        .ADDR_W    (ADDR_W),
        .MIN_LOG2  (MIN_BLK_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .NUM_SIZES (NUM_SIZES)
    ) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (cfg_valid),
        .dsz    (cfg_dsz),
        .base   (cfg_base),
        .addr   (bus_addr),
        .sel    (blk_sel),
        .offset (blk_offset)
    );

    memwin_lane_map #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (blk_sel),
        .big         (cfg_big),
        .acc         (acc_size),
        .lane_addr   (bus_addr[IW-1:0]),
        .wr_data     (wr_data),
        .mem_rd_data (mem_rd_data),
        .lane_en     (lane_en),
        .mem_wr_data (mem_wr_data),
        .rd_data     (rd_data)
    );

    assert_silent_unconfigured_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (!blk_sel && lane_en == '0 && rd_data == '0));

    assert_enables_follow_sel_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        blk_sel |-> (lane_en != '0));

endmodule

// File: tb/memwin_lane_steer_tb.sv
module memwin_lane_steer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] mem_rd_data = '0;
    logic        blk_sel;
    logic [31:0] blk_offset;
    logic [3:0]  lane_en;
    logic [31:0] mem_wr_data;
    logic [31:0] rd_data;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    string scen = "R1";

    // reference configuration state
    logic        m_valid = 1'b0;
    logic        m_big = 1'b0;
    logic [1:0]  m_dsz = '0;
    logic [31:0] m_base = '0;

    always #2 clk = ~clk;

    memwin_lane_steer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .bus_addr    (bus_addr),
        .acc_size    (acc_size),
        .wr_data     (wr_data),
        .mem_rd_data (mem_rd_data),
        .blk_sel     (blk_sel),
        .blk_offset  (blk_offset),
        .lane_en     (lane_en),
        .mem_wr_data (mem_wr_data),
        .rd_data     (rd_data)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
        end else if (cfg_we) begin
            m_valid <= 1'b1;
            m_big   <= cfg_wdata[16];
            m_dsz   <= cfg_wdata[1:0];
            m_base  <= cfg_wdata & 32'hFFE0_0000;
        end
    end

    function automatic string sel_tag();
        if (!m_valid)        return "R1";
        else if (m_dsz == 3) return "R5";
        else                 return "R3";
    endfunction

    function automatic string lane_tag();
        if (acc_size == 2'b00) return m_big ? "R8" : "R7";
        else if (acc_size == 2'b01) return "R9";
        else return "R10";
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %h expected %h (addr %h acc %0d)",
                     tag, scen, what, act, exp, bus_addr, acc_size);
        end
    endtask

    task automatic check_now();
        logic        e_sel;
        logic [31:0] e_off;
        logic [3:0]  e_lane;
        logic [31:0] e_wd;
        logic [31:0] e_rd;
        logic [63:0] m;
        int blog, first, n;
        vectors++;
        blog  = 21 + 2 * int'(m_dsz);
        e_sel = m_valid && (m_dsz != 2'd3) && ((bus_addr >> blog) == (m_base >> blog));
        e_off = e_sel ? (bus_addr & ((32'd1 << blog) - 32'd1)) : 32'd0;
        if (acc_size == 2'b00) begin
            n = 1; first = int'(bus_addr[1:0]);
        end else if (acc_size == 2'b01) begin
            n = 2; first = 2 * int'(bus_addr[1]);
        end else begin
            n = 4; first = 0;
        end
        if (m_big) first = 4 - n - first;
        m      = (64'd1 << (8 * n)) - 64'd1;
        e_lane = e_sel ? 4'(((1 << n) - 1) << first) : 4'd0;
        e_wd   = e_sel ? 32'(((64'(wr_data) & m) << (8 * first))) : 32'd0;
        e_rd   = e_sel ? 32'(((64'(mem_rd_data) >> (8 * first)) & m)) : 32'd0;
        cmp(sel_tag(), 32'(blk_sel), 32'(e_sel), "blk_sel");
        cmp("R6", blk_offset, e_off, "blk_offset");
        cmp(lane_tag(), 32'(lane_en), 32'(e_lane), "lane_en");
        cmp("R11", mem_wr_data, e_wd, "mem_wr_data");
        cmp("R12", rd_data, e_rd, "rd_data");
    endtask

    task automatic step(input logic we, input logic [31:0] cw, input logic [31:0] a,
                        input logic [1:0] acc, input logic [31:0] wd, input logic [31:0] rd);
        @(negedge clk);
        cfg_we      = we;
        cfg_wdata   = cw;
        bus_addr    = a;
        acc_size    = acc;
        wr_data     = wd;
        mem_rd_data = rd;
        #1;
        check_now();
    endtask

    function automatic logic [31:0] pick_addr(input logic [31:0] near, input int span);
        logic [31:0] r;
        r = $urandom;
        if (($urandom % 4) == 0) return r;
        return near ^ (r & ((32'd1 << (span + 1)) - 32'd1));
    endfunction

    task automatic burst(input int count, input logic [31:0] near, input int span);
        for (int i = 0; i < count; i++) begin
            step(1'b0, '0, pick_addr(near, span), 2'($urandom), $urandom, $urandom);
        end
    endtask

    initial begin
        // R1: unconfigured, both in and after reset
        scen = "R1";
        for (int i = 0; i < 3; i++) step(1'b0, '0, $urandom, 2'($urandom), $urandom, $urandom);
        @(negedge clk);
        rst_n = 1'b1;
        burst(40, 32'h0080_0000, 23);
        // a write in the same cycle as an access: still unconfigured
        step(1'b0, '0, 32'h0080_0010, 2'b10, 32'h1122_3344, 32'hA1B2_C3D4);

        // R2: load with little order, 8 MB at 0x0080_0000, the load visible next cycle
        scen = "R2";
        step(1'b1, 32'h0080_0001, 32'h0080_0010, 2'b10, 32'h1122_3344, 32'hA1B2_C3D4);
        step(1'b0, '0, 32'h0080_0010, 2'b10, 32'h1122_3344, 32'hA1B2_C3D4);
        scen = "R7";
        for (int b = 0; b < 4; b++)
            step(1'b0, '0, 32'h0080_0100 + 32'(b), 2'b00, 32'h0000_00E5, 32'h4433_2211);
        scen = "R9";
        for (int b = 0; b < 4; b++)
            step(1'b0, '0, 32'h00FF_FFF0 + 32'(b), 2'b01, 32'h0000_BEEF, 32'h8765_4321);
        scen = "R3";
        step(1'b0, '0, 32'h0100_0000, 2'b10, 32'h0, 32'h0);
        step(1'b0, '0, 32'h007F_FFFF, 2'b00, 32'h0, 32'h0);
        burst(400, 32'h0080_0000, 23);

        // R8: big order, 2 MB at 0x1240_0000
        scen = "R8";
        step(1'b1, 32'h1241_0000, 32'h0, 2'b00, 32'h0, 32'h0);
        for (int b = 0; b < 4; b++)
            step(1'b0, '0, 32'h1240_0000 + 32'(b), 2'b00, 32'h0000_005A, 32'hDDCC_BBAA);
        scen = "R9";
        for (int b = 0; b < 4; b++)
            step(1'b0, '0, 32'h125F_FFF8 + 32'(b), 2'b01, 32'h0000_CAFE, 32'h0102_0304);
        scen = "R10";
        step(1'b0, '0, 32'h1240_0042, 2'b11, 32'h89AB_CDEF, 32'hFEDC_BA98);
        burst(400, 32'h1240_0000, 21);

        // R3: big order, 32 MB at 0x4200_0000
        scen = "R3";
        step(1'b1, 32'h4201_0002, 32'h0, 2'b00, 32'h0, 32'h0);
        step(1'b0, '0, 32'h43FF_FFFF, 2'b00, 32'h0000_0077, 32'h0000_0000);
        step(1'b0, '0, 32'h4400_0000, 2'b10, 32'h0, 32'h0);
        burst(400, 32'h4200_0000, 25);

        // R4: 8 MB with base bits 22:21 set; they must be ignored
        scen = "R4";
        step(1'b1, 32'h0160_0001, 32'h0, 2'b00, 32'h0, 32'h0);
        step(1'b0, '0, 32'h0100_0000, 2'b10, 32'h1234_5678, 32'h9ABC_DEF0);
        step(1'b0, '0, 32'h017F_FFFC, 2'b10, 32'h1234_5678, 32'h9ABC_DEF0);
        burst(300, 32'h0100_0000, 23);

        // R5: reserved size code never selects
        scen = "R5";
        step(1'b1, 32'h0080_0003, 32'h0, 2'b00, 32'h0, 32'h0);
        step(1'b0, '0, 32'h0080_0000, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        burst(200, 32'h0080_0000, 23);

        // R2: back-to-back loads; the last one wins
        scen = "R2";
        step(1'b1, 32'h0020_0000, 32'h0020_0004, 2'b00, 32'h0000_0011, 32'h5566_7788);
        step(1'b1, 32'h0040_0000, 32'h0020_0004, 2'b00, 32'h0000_0011, 32'h5566_7788);
        step(1'b1, 32'h0060_0000, 32'h0040_0004, 2'b00, 32'h0000_0011, 32'h5566_7788);
        step(1'b0, '0, 32'h0060_0004, 2'b01, 32'h0000_2233, 32'h5566_7788);
        burst(200, 32'h0060_0000, 21);

        @(negedge clk);
        cfg_we = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule